// File: doc/BRIEF.md
# SD Card Block Write Sequencer

This block runs complete write transactions against an SD card that has already been brought up. A requester hands over a start sector, a block count and the card's capacity class. The sequencer then drives a command engine and a 512-byte block data path in the right order. It opens the transfer with a single-block or multi-block write command and streams the blocks. After each block it waits out the card's programming busy on DAT0. A multi-block burst is closed with a stop command. Every write ends with a card status query, and the write is accepted only when that query reports no error.

The command engine is assumed to be slow to reflect a new command in its status. For that reason the sequencer never treats a completion strobe as belonging to the current command until the engine has signalled that this command is active. Any failure on the way counts as transient and restarts the whole write once from its first block with the same sector: an engine error, a data path error, a busy timeout or a status word carrying error bits. Only a second failure is reported. Rewriting identical data to the same sectors is harmless, so the retry is safe.

Top module: `sd_wr_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error` and `cmd_issue` are low, `req_ready` is high and `status` is zero.
- R2: A count of one opens with command index 24 and a count above one opens with index 25. In both cases exactly `count` pulses of `blk_start` follow, one per 512-byte block.
- R3: When `req_ccs` is 1 (block addressing) the write command argument equals the sector. When it is 0 (byte addressing) the argument equals the sector multiplied by 512, truncated to 32 bits.
- R4: After each `cmd_issue` pulse, a `cmd_done` (and its `cmd_err`) is ignored until `cmd_active` has been seen high for that command.
- R5: While the sequencer waits for DAT0 busy to end, `dat0_busy` staying high for `BUSY_LIMIT` counted cycles is a failure. The wait is abandoned without waiting for the line to release.
- R6: Every write ends with command index 13 and argument `{rca,16'h0}`. Its response is shown on `status`. The write succeeds only if response bits 31 to 19 are all zero.
- R7: After the last block of a multi-block write, command index 12 is issued and its DAT0 busy is waited out before the status query.
- R8: On the first failure of a request, the whole write is repeated once from its first command with the same index and argument. A second failure pulses `error` and a success pulses `done`.
- R9: A request with a count of zero issues no command and no block, pulses `error` on the next cycle and leaves `req_ready` high again one cycle later.
- R10: `busy` is high and `req_ready` low from the cycle after a request is accepted until `done` or `error` has pulsed. `done` and `error` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle when valid |
| req_sector | input | 32 | First sector to write |
| req_count | input | CNT_W | Number of 512-byte blocks |
| req_ccs | input | 1 | 1 = block addressed card, 0 = byte addressed card |
| rca | input | 16 | Relative card address for the status query |
| cmd_issue | output | 1 | One-cycle command launch to the engine |
| cmd_index | output | 6 | Command index with `cmd_issue` |
| cmd_arg | output | 32 | Command argument with `cmd_issue` |
| cmd_active | input | 1 | Engine status reflects the newly issued command |
| cmd_done | input | 1 | Engine completion strobe |
| cmd_err | input | 1 | Engine error, qualified by `cmd_done` |
| cmd_resp | input | 32 | Short response, qualified by `cmd_done` |
| blk_start | output | 1 | One-cycle request to send the next 512-byte block |
| blk_done | input | 1 | Block sent |
| blk_err | input | 1 | Block failed, qualified by `blk_done` |
| dat0_busy | input | 1 | Card holds DAT0 low (programming) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Request finished without error |
| error | output | 1 | Request failed or was rejected |
| status | output | 32 | Card status from the most recent status query |

## Verification
The bench builds the sequencer with `BUSY_LIMIT` set to 40 and `CNT_W` left at 16. The short busy window brings the timeout path within a few hundred cycles. Its two-attempt error outcome and its latency bound, at least twice the limit and well short of the card's release, can then be checked directly. The behavioural engine can hold back `cmd_active` and inject a stray failing completion. It can also fail only the first write command, return a status word with error bits, or stretch DAT0 busy. These controls reach the stale-status, single-retry, double-failure and stop-command paths, alongside byte and block addressing.

// File: rtl/sd_wr_pkg.sv
package sd_wr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_START,
    ST_RESP,
    ST_DATA,
    ST_DWAIT,
    ST_BUSY,
    ST_OK,
    ST_FAIL
  } wr_state_t;

  typedef enum logic [1:0] {
    PH_WRITE,
    PH_STOP,
    PH_STAT
  } wr_phase_t;

  localparam logic [5:0]  CMD_WR_ONE   = 6'd24;
  localparam logic [5:0]  CMD_WR_MANY  = 6'd25;
  localparam logic [5:0]  CMD_STOP     = 6'd12;
  localparam logic [5:0]  CMD_STATUS   = 6'd13;
  localparam int          BLK_SHIFT    = 9;
  localparam logic [31:0] CARD_ERR_MSK = 32'hFFF8_0000;

endpackage

// File: rtl/sd_wr_cmdsel.sv
module sd_wr_cmdsel
  import sd_wr_pkg::*;
(
  input  wr_phase_t   phase,
  input  logic        multi,
  input  logic        ccs,
  input  logic [31:0] sector,
  input  logic [15:0] rca,
  output logic [5:0]  idx,
  output logic [31:0] arg
);

  always_comb begin
    case (phase)
      PH_WRITE: begin
        idx = multi ? CMD_WR_MANY : CMD_WR_ONE;
        arg = ccs ? sector : (sector << BLK_SHIFT);
      end
      PH_STOP: begin
        idx = CMD_STOP;
        arg = '0;
      end
      default: begin
        idx = CMD_STATUS;
        arg = {rca, 16'h0000};
      end
    endcase
  end

endmodule

// File: rtl/sd_wr_busytmr.sv
module sd_wr_busytmr #(
  parameter int LIMIT = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == CW'(LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (en && !expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  expiry_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(en));

endmodule

// File: rtl/sd_wr_seq.sv
module sd_wr_seq
  import sd_wr_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int BUSY_LIMIT = 50_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_sector,
  input  logic [CNT_W-1:0] req_count,
  input  logic             req_ccs,
  input  logic [15:0]      rca,
  output logic             cmd_issue,
  output logic [5:0]       cmd_index,
  output logic [31:0]      cmd_arg,
  input  logic             cmd_active,
  input  logic             cmd_done,
  input  logic             cmd_err,
  input  logic [31:0]      cmd_resp,
  output logic             blk_start,
  input  logic             blk_done,
  input  logic             blk_err,
  input  logic             dat0_busy,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [31:0]      status
);

  wr_state_t        st_q, st_d;
  wr_phase_t        ph_q, ph_d;
  logic [CNT_W-1:0] left_q, left_d, count_q, count_d;
  logic [31:0]      sector_q, sector_d, status_q, status_d;
  logic [15:0]      rca_q, rca_d;
  logic             ccs_q, ccs_d, multi_q, multi_d, retry_q, retry_d;
  logic             tmr_expired, fail;

  sd_wr_cmdsel u_cmdsel (
    .phase  (ph_q),
    .multi  (multi_q),
    .ccs    (ccs_q),
    .sector (sector_q),
    .rca    (rca_q),
    .idx    (cmd_index),
    .arg    (cmd_arg)
  );

  sd_wr_busytmr #(.LIMIT(BUSY_LIMIT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_q != ST_BUSY),
    .en      ((st_q == ST_BUSY) && dat0_busy),
    .expired (tmr_expired)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign cmd_issue = (st_q == ST_CMD);
  assign blk_start = (st_q == ST_DATA);
  assign done      = (st_q == ST_OK);
  assign error     = (st_q == ST_FAIL);
  assign status    = status_q;

  // next-state process
  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    left_d   = left_q;
    count_d  = count_q;
    sector_d = sector_q;
    status_d = status_q;
    rca_d    = rca_q;
    ccs_d    = ccs_q;
    multi_d  = multi_q;
    retry_d  = retry_q;
    fail     = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        if (req_count == '0) begin
          st_d = ST_FAIL;
        end else begin
          st_d     = ST_CMD;
          ph_d     = PH_WRITE;
          left_d   = req_count;
          count_d  = req_count;
          sector_d = req_sector;
          rca_d    = rca;
          ccs_d    = req_ccs;
          multi_d  = (req_count != CNT_W'(1));
          retry_d  = 1'b0;
        end
      end
      ST_CMD:   st_d = ST_START;
      ST_START: if (cmd_active) st_d = ST_RESP;
      ST_RESP: if (cmd_done) begin
        if (cmd_err) fail = 1'b1;
        else begin
          case (ph_q)
            PH_WRITE: st_d = ST_DATA;
            PH_STOP:  st_d = ST_BUSY;
            default: begin
              status_d = cmd_resp;
              if ((cmd_resp & CARD_ERR_MSK) != '0) fail = 1'b1;
              else                                 st_d = ST_OK;
            end
          endcase
        end
      end
      ST_DATA:  st_d = ST_DWAIT;
      ST_DWAIT: if (blk_done) begin
        if (blk_err) fail = 1'b1;
        else begin
          left_d = left_q - 1'b1;
          st_d   = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (!dat0_busy) begin
          if (ph_q == PH_WRITE && left_q != '0) begin
            st_d = ST_DATA;
          end else if (ph_q == PH_WRITE && multi_q) begin
            ph_d = PH_STOP;
            st_d = ST_CMD;
          end else begin
            ph_d = PH_STAT;
            st_d = ST_CMD;
          end
        end else if (tmr_expired) begin
          fail = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (fail) begin
      if (!retry_q) begin
        retry_d = 1'b1;
        ph_d    = PH_WRITE;
        left_d  = count_q;
        st_d    = ST_CMD;
      end else begin
        st_d = ST_FAIL;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ph_q     <= PH_WRITE;
      left_q   <= '0;
      count_q  <= '0;
      sector_q <= '0;
      status_q <= '0;
      rca_q    <= '0;
      ccs_q    <= 1'b0;
      multi_q  <= 1'b0;
      retry_q  <= 1'b0;
    end else begin
      st_q     <= st_d;
      ph_q     <= ph_d;
      left_q   <= left_d;
      count_q  <= count_d;
      sector_q <= sector_d;
      status_q <= status_d;
      rca_q    <= rca_d;
      ccs_q    <= ccs_d;
      multi_q  <= multi_d;
      retry_q  <= retry_d;
    end
  end

  // R10
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_count != '0) |=> (busy && !req_ready));

  // R10
  done_error_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  // R4
  issue_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_issue |=> (!cmd_issue && !blk_start));

  // R6
  stat_arg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && cmd_index == CMD_STATUS) |-> (cmd_arg == {rca_q, 16'h0000}));

  // R2
  blk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> !blk_start);

endmodule

// File: tb/sd_wr_seq_tb.sv
module sd_wr_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_sector = '0;
  logic [15:0] req_count = '0;
  logic        req_ccs = 1'b0;
  logic [15:0] rca = 16'hBEEF;
  logic        cmd_issue;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic        cmd_active = 1'b0;
  logic        cmd_done = 1'b0;
  logic        cmd_err = 1'b0;
  logic [31:0] cmd_resp = '0;
  logic        blk_start;
  logic        blk_done = 1'b0;
  logic        blk_err = 1'b0;
  logic        dat0_busy = 1'b0;
  logic        busy, done, error;
  logic [31:0] status;

  always #5 clk = ~clk;

  sd_wr_seq #(.CNT_W(16), .BUSY_LIMIT(40)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sector(req_sector), .req_count(req_count), .req_ccs(req_ccs), .rca(rca),
    .cmd_issue(cmd_issue), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .cmd_active(cmd_active), .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_resp(cmd_resp),
    .blk_start(blk_start), .blk_done(blk_done), .blk_err(blk_err), .dat0_busy(dat0_busy),
    .busy(busy), .done(done), .error(error), .status(status)
  );

  int checks = 0;
  int errors = 0;
  int cyc_total = 0;

  // engine / card model configuration and log
  int          log_idx [16];
  logic [31:0] log_arg [16];
  int          nlog, nblk;
  bit          cfg_stale, cfg_err_first_wr, wr_seen;
  logic [31:0] cfg_stat_resp;
  int          cfg_busy;
  int          eph, edly, bdly, dbusy_cnt, cur_idx;
  bit          cur_err;
  logic [31:0] cur_resp;
  bit          got_done, got_err;
  int          req_cycles;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural command engine and card, driven away from the active edge
  initial begin
    eph = 0; edly = 0; bdly = 0; dbusy_cnt = 0; nlog = 0; nblk = 0;
    forever begin
      @(negedge clk);
      cyc_total++;
      cmd_done = 1'b0; cmd_err = 1'b0; blk_done = 1'b0;
      if (dbusy_cnt > 0) begin
        dbusy_cnt--;
        if (dbusy_cnt == 0) dat0_busy = 1'b0;
      end
      if (eph == 1) begin
        if (cfg_stale && edly == 3) begin cmd_done = 1'b1; cmd_err = 1'b1; end
        if (edly == 0) begin cmd_active = 1'b1; eph = 2; edly = 2; end
        else edly--;
      end else if (eph == 2) begin
        if (edly == 0) begin
          cmd_active = 1'b0; cmd_done = 1'b1; cmd_err = cur_err; cmd_resp = cur_resp; eph = 0;
          if (cur_idx == 12) begin dat0_busy = 1'b1; dbusy_cnt = cfg_busy; end
        end else edly--;
      end
      if (bdly > 0) begin
        bdly--;
        if (bdly == 0) begin blk_done = 1'b1; dat0_busy = 1'b1; dbusy_cnt = cfg_busy; end
      end
      if (cmd_issue) begin
        if (nlog < 16) begin log_idx[nlog] = int'(cmd_index); log_arg[nlog] = cmd_arg; end
        nlog++;
        cur_idx  = int'(cmd_index);
        cur_err  = (cmd_index == 6'd24 || cmd_index == 6'd25) && cfg_err_first_wr && !wr_seen;
        if (cmd_index == 6'd24 || cmd_index == 6'd25) wr_seen = 1'b1;
        cur_resp = (cmd_index == 6'd13) ? cfg_stat_resp : 32'h0;
        eph  = 1;
        edly = cfg_stale ? 5 : 0;
      end
      if (blk_start) begin nblk++; bdly = 3; end
    end
  end

  task automatic setup(bit stale, bit err_first, logic [31:0] stat, int bcy);
    cfg_stale = stale; cfg_err_first_wr = err_first; cfg_stat_resp = stat; cfg_busy = bcy;
    wr_seen = 1'b0; nlog = 0; nblk = 0; dat0_busy = 1'b0; dbusy_cnt = 0;
  endtask

  task automatic do_req(logic [31:0] sec, logic [15:0] cnt, logic ccs);
    @(negedge clk);
    req_valid = 1'b1; req_sector = sec; req_count = cnt; req_ccs = ccs;
    @(negedge clk);
    req_valid = 1'b0;
    req_cycles = 1;
    while (!done && !error && req_cycles < 3000) begin
      @(negedge clk);
      req_cycles++;
    end
    got_done = done; got_err = error;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 busy", 32'(busy), 0);
    check("R1 req_ready", 32'(req_ready), 1);
    check("R1 done/error", {30'd0, done, error}, 0);
    check("R1 cmd_issue", 32'(cmd_issue), 0);
    check("R1 status", status, 0);
  endtask

  task automatic t_single_block;
    setup(0, 0, 32'h0000_0900, 4);
    do_req(32'h0000_1234, 16'd1, 1'b1);
    check("R8 done", {30'd0, got_done, got_err}, 2);
    check("R2 cmd count", nlog, 2);
    check("R2 index 24", log_idx[0], 24);
    check("R3 block addr arg", log_arg[0], 32'h0000_1234);
    check("R6 index 13", log_idx[1], 13);
    check("R6 rca arg", log_arg[1], 32'hBEEF_0000);
    check("R2 blocks", nblk, 1);
    check("R6 status", status, 32'h0000_0900);
    check("R10 idle after done", {30'd0, busy, req_ready}, 1);
  endtask

  task automatic t_byte_addr;
    setup(0, 0, 32'h0000_0900, 2);
    do_req(32'h0000_0005, 16'd1, 1'b0);
    check("R3 byte addr arg", log_arg[0], 32'h0000_0A00);
    check("R3 done", 32'(got_done), 1);
    setup(0, 0, 32'h0000_0900, 2);
    do_req(32'h0080_0001, 16'd1, 1'b0);
    check("R3 byte addr truncation", log_arg[0], 32'h0000_0200);
  endtask

  task automatic t_multi_block;
    setup(0, 0, 32'h0000_0900, 5);
    do_req(32'h0000_0100, 16'd3, 1'b1);
    check("R2 index 25", log_idx[0], 25);
    check("R2 blocks", nblk, 3);
    check("R7 cmd count", nlog, 3);
    check("R7 index 12", log_idx[1], 12);
    check("R7 then 13", log_idx[2], 13);
    check("R7 done", {30'd0, got_done, got_err}, 2);
  endtask

  task automatic t_retry_once;
    setup(0, 1, 32'h0000_0900, 2);
    do_req(32'h0000_0042, 16'd2, 1'b1);
    check("R8 cmd count", nlog, 4);
    check("R8 repeat index", log_idx[1], 25);
    check("R8 repeat arg", log_arg[1], 32'h0000_0042);
    check("R8 blocks only from retry", nblk, 2);
    check("R8 success after retry", {30'd0, got_done, got_err}, 2);
  endtask

  task automatic t_double_fail;
    setup(0, 0, 32'h0400_0900, 2);
    do_req(32'h0000_0077, 16'd1, 1'b1);
    check("R6 cmd count", nlog, 4);
    check("R8 second write idx", log_idx[2], 24);
    check("R6 status error bits", status, 32'h0400_0900);
    check("R8 error", {30'd0, got_done, got_err}, 1);
  endtask

  task automatic t_timeout;
    setup(0, 0, 32'h0000_0900, 500);
    do_req(32'h0000_0009, 16'd1, 1'b1);
    check("R5 error", {30'd0, got_done, got_err}, 1);
    check("R5 no status query", nlog, 2);
    check("R5 waited two windows", 32'(req_cycles >= 80), 1);
    check("R5 did not wait release", 32'(req_cycles < 400), 1);
    repeat (500) @(negedge clk);
  endtask

  task automatic t_zero_count;
    setup(0, 0, 32'h0000_0900, 2);
    do_req(32'h0000_0001, 16'd0, 1'b1);
    check("R9 error pulse", {30'd0, got_done, got_err}, 1);
    check("R9 reject latency", req_cycles, 1);
    repeat (8) @(negedge clk);
    check("R9 no command", nlog, 0);
    check("R9 no block", nblk, 0);
    check("R9 ready", 32'(req_ready), 1);
    do_req(32'h0000_0003, 16'd1, 1'b1);
    check("R9 next request ok", 32'(got_done), 1);
  endtask

  task automatic t_stale;
    setup(1, 0, 32'h0000_0900, 2);
    do_req(32'h0000_0055, 16'd1, 1'b1);
    check("R4 stray completion ignored", nlog, 2);
    check("R4 done", {30'd0, got_done, got_err}, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_block();
    t_byte_addr();
    t_multi_block();
    t_retry_once();
    t_double_fail();
    t_timeout();
    t_zero_count();
    t_stale();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc_total > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc_total);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule